// File: doc/BRIEF.md
# Software-Commanded Reset Sequencer

This block produces the processor reset, the peripheral reset and an open-drain pull-down enable for a board-level reset pin. Software issues reset commands through a small register port clocked by the fast master clock. Each command is guarded by a key byte. A command asserts the selected internal resets in the next master-clock cycle. The sequence that follows runs on a slow clock: a fixed software phase, an optional programmable pin pulse, a wait for the real pin level to read high, the peripheral release, and then the processor release a few slow cycles later.

When the pin is pulled low from outside while the block is idle, both internal resets are held until the pin returns high. They are then released in the same staged order. A status field reports whether the last reset came from power-on, from software or from the pin. A busy flag covers the whole software sequence, including the handshake back to the master clock. Command and mode writes are dropped while busy is high.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `proc_rst_n` and `periph_rst_n` are low (asynchronously), `pin_drive_low` is 0, `busy` is 0 and `cause` is 0.
- R2: A write with `wr_sel`=0, `wr_data[31:24]`=0xA5 and at least one of `wr_data[0]` (processor), `wr_data[1]` (peripheral), `wr_data[2]` (external pin) set raises `busy`. It also drives low exactly the selected internal resets, and the sampling edge of that write is the last edge before they fall.
- R3: A write whose key byte is not 0xA5, or a control write with bits [2:0] all zero, changes nothing: no reset, no busy, and no change of the stored pulse length.
- R4: While `busy` is high, every write (control or mode) is ignored. A processor command written during a peripheral-only sequence never asserts `proc_rst_n`.
- R5: Every software sequence starts with a 2-slow-cycle phase. With the external command, `pin_drive_low` is then high for exactly 2^(L+1) slow cycles, where L is `wr_data[3:0]` of the last accepted mode write (`wr_sel`=1, same key). L resets to 0.
- R6: The internal resets stay asserted while the synchronized pin reads low. After the pin rises, the peripheral release follows at the third slow edge (two synchronizer stages plus the sequencer register).
- R7: When both internal resets were asserted, the processor reset releases exactly 3 slow cycles after the peripheral reset, and never before it.
- R8: `cause` becomes 3 when a software sequence starts. It becomes 4 when the pin is pulled low from outside while the block is idle; both internal resets then assert and `busy` stays 0.
- R9: `busy` falls only after all commanded resets are released. The next command is then accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Fast master clock for the register port |
| slclk | input | 1 | Slow clock that times the reset sequence |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | Register write strobe, one mclk cycle |
| wr_sel | input | 1 | 0 selects the command register, 1 the mode register |
| wr_data | input | 32 | Write data: key in [31:24], command bits or length field below |
| pin_in | input | 1 | Level read back from the external reset pin |
| pin_drive_low | output | 1 | 1 enables the open-drain pull-down on the reset pin |
| proc_rst_n | output | 1 | Active-low processor reset |
| periph_rst_n | output | 1 | Active-low peripheral reset |
| busy | output | 1 | High while a software sequence and its handshake are in progress |
| cause | output | 3 | Cause of the last reset: 0 power-on, 3 software, 4 pin |

## Verification
The bench uses the default 4-bit length field and a slow clock 25 times slower than the master clock. It programs lengths 0, 2 and 3, so pulses of 2, 8 and 16 slow cycles stay short. An outside pull is modelled on the pin. It holds the pin low past the end of the programmed pulse, and it also fires while the block is idle. This puts the three-edge release latency and the user-reset path within reach. The 3-cycle processor delay is counted at slow-clock falling edges in both the software and the pin-initiated sequences.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SW,
        SQ_EXT,
        SQ_PIN,
        SQ_PROC,
        SQ_DONE
    } seq_state_e;

    localparam logic [2:0] CAUSE_POR  = 3'd0;
    localparam logic [2:0] CAUSE_SW   = 3'd3;
    localparam logic [2:0] CAUSE_USER = 3'd4;

    localparam int CMD_PROC = 0;
    localparam int CMD_PER  = 1;
    localparam int CMD_EXT  = 2;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {2{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[1];

endmodule

// File: rtl/rsc_cmd.sv
module rsc_cmd
    import rsc_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          LEN_W  = 4,
    parameter logic [7:0]  KEY    = 8'hA5
) (
    input  logic              mclk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seq_done,
    output logic              req,
    output logic              hold_proc,
    output logic              hold_per,
    output logic              hold_ext,
    output logic [LEN_W-1:0]  len,
    output logic              busy
);

    typedef struct packed {
        logic             req;
        logic             proc;
        logic             per;
        logic             ext;
        logic [LEN_W-1:0] len;
    } cmd_t;

    cmd_t s_d, s_q;
    logic done_m;
    logic key_ok, any_cmd, idle;
    logic data_unused;

    rsc_sync #(.RST_VAL(1'b0)) u_done_sync (
        .clk  (mclk),
        .rst_n(por_n),
        .din  (seq_done),
        .dout (done_m)
    );

    assign data_unused = ^wr_data[DATA_W-9:LEN_W];

    always_comb begin
        key_ok  = (wr_data[DATA_W-1 -: 8] == KEY);
        any_cmd = wr_data[CMD_PROC] | wr_data[CMD_PER] | wr_data[CMD_EXT];
        idle    = !s_q.req && !done_m;
        s_d     = s_q;
        if (s_q.req && done_m) begin
            // slow side has finished: drop the request and all holds together
            s_d.req  = 1'b0;
            s_d.proc = 1'b0;
            s_d.per  = 1'b0;
            s_d.ext  = 1'b0;
        end else if (wr_en && key_ok && idle) begin
            if (!wr_sel) begin
                if (any_cmd) begin
                    s_d.req  = 1'b1;
                    s_d.proc = wr_data[CMD_PROC];
                    s_d.per  = wr_data[CMD_PER];
                    s_d.ext  = wr_data[CMD_EXT];
                end
            end else begin
                s_d.len = wr_data[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge mclk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req       = s_q.req;
    assign hold_proc = s_q.proc;
    assign hold_per  = s_q.per;
    assign hold_ext  = s_q.ext;
    assign len       = s_q.len;
    assign busy      = s_q.req | done_m;

endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
    import rsc_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int SW_LEN   = 2,
    parameter int PROC_DLY = 3
) (
    input  logic             slclk,
    input  logic             por_n,
    input  logic             req,
    input  logic             ext_cmd,
    input  logic [LEN_W-1:0] len,
    input  logic             pin_in,
    output logic             drive,
    output logic             rel_per,
    output logic             rel_proc,
    output logic             usr,
    output logic             done,
    output logic [2:0]       cause
);

    localparam int CNT_W = 2 ** LEN_W;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             drive;
        logic             rel_per;
        logic             rel_proc;
        logic             usr;
        logic             done;
        logic [2:0]       cause;
    } seq_t;

    seq_t s_d, s_q;
    logic req_s, pin_s;

    rsc_sync #(.RST_VAL(1'b0)) u_req_sync (
        .clk  (slclk),
        .rst_n(por_n),
        .din  (req),
        .dout (req_s)
    );

    rsc_sync #(.RST_VAL(1'b1)) u_pin_sync (
        .clk  (slclk),
        .rst_n(por_n),
        .din  (pin_in),
        .dout (pin_s)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SQ_IDLE: begin
                if (req_s && !s_q.done) begin
                    s_d.st    = SQ_SW;
                    s_d.cnt   = CNT_W'(SW_LEN - 1);
                    s_d.cause = CAUSE_SW;
                end else if (!req_s && !pin_s) begin
                    s_d.st    = SQ_PIN;
                    s_d.usr   = 1'b1;
                    s_d.cause = CAUSE_USER;
                end
            end
            SQ_SW: begin
                if (s_q.cnt == '0) begin
                    if (ext_cmd) begin
                        s_d.st    = SQ_EXT;
                        s_d.cnt   = {CNT_W{1'b1}} >> (LEN_W'(CNT_W - 1) - len);
                        s_d.drive = 1'b1;
                    end else begin
                        s_d.st = SQ_PIN;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            SQ_EXT: begin
                if (s_q.cnt == '0) begin
                    s_d.drive = 1'b0;
                    s_d.st    = SQ_PIN;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            SQ_PIN: begin
                if (pin_s) begin
                    s_d.rel_per = 1'b1;
                    s_d.st      = SQ_PROC;
                    s_d.cnt     = CNT_W'(PROC_DLY - 1);
                end
            end
            SQ_PROC: begin
                if (s_q.cnt == '0) begin
                    if (s_q.usr) begin
                        s_d.usr     = 1'b0;
                        s_d.rel_per = 1'b0;
                        s_d.st      = SQ_IDLE;
                    end else begin
                        s_d.rel_proc = 1'b1;
                        s_d.done     = 1'b1;
                        s_d.st       = SQ_DONE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            SQ_DONE: begin
                if (!req_s) begin
                    s_d.done     = 1'b0;
                    s_d.rel_per  = 1'b0;
                    s_d.rel_proc = 1'b0;
                    s_d.st       = SQ_IDLE;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge slclk or negedge por_n) begin
        if (!por_n) begin
            s_q       <= '0;
            s_q.st    <= SQ_IDLE;
            s_q.cause <= CAUSE_POR;
        end else begin
            s_q <= s_d;
        end
    end

    assign drive    = s_q.drive;
    assign rel_per  = s_q.rel_per;
    assign rel_proc = s_q.rel_proc;
    assign usr      = s_q.usr;
    assign done     = s_q.done;
    assign cause    = s_q.cause;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
    parameter int         DATA_W   = 32,
    parameter int         LEN_W    = 4,
    parameter logic [7:0] KEY      = 8'hA5,
    parameter int         SW_LEN   = 2,
    parameter int         PROC_DLY = 3
) (
    input  logic              mclk,
    input  logic              slclk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pin_in,
    output logic              pin_drive_low,
    output logic              proc_rst_n,
    output logic              periph_rst_n,
    output logic              busy,
    output logic [2:0]        cause
);

    logic             req, hold_proc, hold_per, hold_ext;
    logic [LEN_W-1:0] len_m;
    logic             rel_per, rel_proc, usr, done;

    rsc_cmd #(.DATA_W(DATA_W), .LEN_W(LEN_W), .KEY(KEY)) u_cmd (
        .mclk     (mclk),
        .por_n    (por_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .seq_done (done),
        .req      (req),
        .hold_proc(hold_proc),
        .hold_per (hold_per),
        .hold_ext (hold_ext),
        .len      (len_m),
        .busy     (busy)
    );

    rsc_seq #(.LEN_W(LEN_W), .SW_LEN(SW_LEN), .PROC_DLY(PROC_DLY)) u_seq (
        .slclk   (slclk),
        .por_n   (por_n),
        .req     (req),
        .ext_cmd (hold_ext),
        .len     (len_m),
        .pin_in  (pin_in),
        .drive   (pin_drive_low),
        .rel_per (rel_per),
        .rel_proc(rel_proc),
        .usr     (usr),
        .done    (done),
        .cause   (cause)
    );

    // assertion from master-clock holds, release from slow-clock flags
    assign periph_rst_n = por_n & ~((hold_per  | usr) & ~rel_per);
    assign proc_rst_n   = por_n & ~((hold_proc | usr) & ~rel_proc);

endmodule

// File: rtl/rsc_chk.sv
module rsc_chk
    import rsc_pkg::*;
(
    input logic       mclk,
    input logic       slclk,
    input logic       por_n,
    input logic       busy,
    input logic       pin_in,
    input logic       pin_drive_low,
    input logic       proc_rst_n,
    input logic       periph_rst_n,
    input logic [2:0] cause,
    input logic       hold_proc,
    input logic       hold_per,
    input logic       hold_ext
);

    // R4: captured command cannot change while a sequence is pending
    assert_cmd_frozen_R4: assert property (@(posedge mclk) disable iff (!por_n)
        ($past(busy) && (hold_proc || hold_per || hold_ext))
        |-> $stable({hold_proc, hold_per, hold_ext}));

    // R5: the pin is only pulled low inside a software sequence
    assert_drive_in_seq_R5: assert property (@(posedge mclk) disable iff (!por_n)
        pin_drive_low |-> busy);

    // R6: a low pin seen over three slow samples keeps the peripheral reset
    assert_hold_pin_low_R6: assert property (@(posedge slclk) disable iff (!por_n)
        (!periph_rst_n && !pin_in && !$past(pin_in) && !$past(pin_in, 2))
        |=> !periph_rst_n);

    // R7: processor never leaves reset ahead of the peripherals
    assert_proc_after_per_R7: assert property (@(posedge slclk) disable iff (!por_n)
        $rose(proc_rst_n) |-> periph_rst_n);

    // R8: cause only carries one of the defined codes
    assert_cause_legal_R8: assert property (@(posedge slclk) disable iff (!por_n)
        (cause == CAUSE_POR) || (cause == CAUSE_SW) || (cause == CAUSE_USER));

endmodule

bind rst_seq_ctrl rsc_chk u_chk (
    .mclk         (mclk),
    .slclk        (slclk),
    .por_n        (por_n),
    .busy         (busy),
    .pin_in       (pin_in),
    .pin_drive_low(pin_drive_low),
    .proc_rst_n   (proc_rst_n),
    .periph_rst_n (periph_rst_n),
    .cause        (cause),
    .hold_proc    (hold_proc),
    .hold_per     (hold_per),
    .hold_ext     (hold_ext)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;

    localparam logic [7:0] KEY = 8'hA5;

    // {cmd[2:0], len[3:0], expected drive cycles[7:0]}
    localparam logic [14:0] VEC [5] = '{
        {3'b001, 4'd0, 8'd0},
        {3'b010, 4'd0, 8'd0},
        {3'b100, 4'd0, 8'd2},
        {3'b111, 4'd2, 8'd8},
        {3'b110, 4'd3, 8'd16}
    };

    logic        mclk = 1'b0, slclk = 1'b0, por_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, ext_pull = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pin_in, pin_drive_low, proc_rst_n, periph_rst_n, busy;
    logic [2:0]  cause;
    int          checks = 0, errors = 0;

    always #4   mclk  = ~mclk;
    always #100 slclk = ~slclk;

    assign pin_in = !(pin_drive_low || ext_pull);

    rst_seq_ctrl u0 (
        .mclk(mclk), .slclk(slclk), .por_n(por_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pin_in(pin_in), .pin_drive_low(pin_drive_low),
        .proc_rst_n(proc_rst_n), .periph_rst_n(periph_rst_n),
        .busy(busy), .cause(cause)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge mclk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge mclk);
        wr_en = 1'b0;
    endtask

    // counts slow cycles of pin drive and of periph-released/proc-held, until busy falls
    task automatic measure(output int drv, output int dly);
        drv = 0; dly = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge slclk);
            if (pin_drive_low) drv++;
            if (periph_rst_n && !proc_rst_n) dly++;
            if (!busy) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge mclk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int drv, dly, n;
        logic [2:0] cmd;
        logic [3:0] len;
        #50;
        check("R1 proc low",   proc_rst_n, 0);
        check("R1 periph low", periph_rst_n, 0);
        check("R1 drive",      pin_drive_low, 0);
        check("R1 busy",       busy, 0);
        check("R1 cause",      cause, 0);
        #53 por_n = 1'b1;
        #20;
        check("R1 proc released", proc_rst_n, 1);

        // R3: wrong key, empty command, wrong-key mode write
        wr(1'b0, {8'h5A, 21'h0, 3'b111});
        repeat (4) @(negedge slclk);
        check("R3 bad key busy",   busy, 0);
        check("R3 bad key resets", proc_rst_n && periph_rst_n, 1);
        check("R3 bad key drive",  pin_drive_low, 0);
        wr(1'b0, {KEY, 21'h0, 3'b000});
        repeat (2) @(negedge slclk);
        check("R3 empty cmd busy", busy, 0);
        check("R3 cause kept",     cause, 0);
        wr(1'b1, {8'h00, 20'h0, 4'd3});
        wr(1'b0, {KEY, 21'h0, 3'b100});
        measure(drv, dly);
        check("R3 length unchanged", drv, 2);

        // table of software commands
        for (int v = 0; v < 5; v++) begin
            cmd = VEC[v][14:12];
            len = VEC[v][11:8];
            wr(1'b1, {KEY, 20'h0, len});
            wr(1'b0, {KEY, 21'h0, cmd});
            check("R2 proc asserted",   !proc_rst_n, cmd[0]);
            check("R2 periph asserted", !periph_rst_n, cmd[1]);
            check("R2 busy",            busy, 1);
            measure(drv, dly);
            check("R5 drive length", drv, int'(VEC[v][7:0]));
            if (cmd[0] && cmd[1]) check("R7 proc delay", dly, 3);
            check("R9 busy cleared", busy, 0);
            check("R9 all released", proc_rst_n && periph_rst_n, 1);
            check("R8 cause sw",     cause, 3);
        end

        // R4: write during a peripheral-only sequence
        wr(1'b1, {KEY, 20'h0, 4'd0});
        wr(1'b0, {KEY, 21'h0, 3'b010});
        wr(1'b0, {KEY, 21'h0, 3'b101});
        wr(1'b1, {KEY, 20'h0, 4'd3});
        check("R4 proc untouched", proc_rst_n, 1);
        measure(drv, dly);
        check("R4 no proc hold", dly, 0);
        check("R4 no drive",     drv, 0);
        wr(1'b0, {KEY, 21'h0, 3'b100});
        measure(drv, dly);
        check("R4 mode write ignored", drv, 2);

        // R6: outside driver holds the pin past the pulse
        wr(1'b0, {KEY, 21'h0, 3'b110});
        @(negedge slclk);
        ext_pull = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge slclk);
            if (!pin_drive_low) break;
        end
        repeat (6) @(negedge slclk);
        check("R6 held while pin low", periph_rst_n, 0);
        check("R6 busy while pin low", busy, 1);
        ext_pull = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge slclk);
            if (periph_rst_n) break;
            n++;
        end
        check("R6 release latency", n, 2);
        measure(drv, dly);
        check("R9 busy after pull", busy, 0);

        // R8: user reset from the pin while idle
        @(negedge slclk);
        ext_pull = 1'b1;
        repeat (4) @(negedge slclk);
        check("R8 user proc asserted",   proc_rst_n, 0);
        check("R8 user periph asserted", periph_rst_n, 0);
        check("R8 user no busy",         busy, 0);
        ext_pull = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge slclk);
            if (periph_rst_n) break;
            n++;
        end
        check("R6 user release latency", n, 2);
        n = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge slclk);
            if (proc_rst_n) break;
            n++;
        end
        check("R7 user proc delay", n, 3);
        check("R8 cause user",      cause, 4);

        // R9: command accepted again after a user reset
        wr(1'b0, {KEY, 21'h0, 3'b001});
        check("R9 new cmd accepted", proc_rst_n, 0);
        measure(drv, dly);
        check("R9 busy done",   busy, 0);
        check("R8 cause again", cause, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule